// File: doc/BRIEF.md
# Byte-Accessed 16-bit Up/Down Timer Counter

This block is a 16-bit timer counter that a processor reaches through an 8-bit bus. The count is seen as a low-byte location and a high-byte location. The high-byte location never reaches the counter directly. It goes through one shared 8-bit holding byte. A low-byte read fills the holding byte, and a low-byte write empties it into the counter. This way every 16-bit read or write happens as a single snapshot or load, even while the counter is running.

The counter advances once per qualified tick. A tick is a single-cycle strobe that counts only while the clock-select field is nonzero. A 2-bit mode input picks the sequence: free up-count with wrap, up-count with clear at a programmable limit, or triangle up/down between zero and the limit. The block drives registered at-limit and at-zero indications. It also keeps an overflow flag that software clears, and that flag is the interrupt request.

Top module: `bytewide_timer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, the count is 0x0000, `irq` is 0, `bus_rdata` is 0x00, `at_bottom` is 1 and `at_top` is 0.
- R2: Bus address 1 reaches only the holding byte. A write there changes the holding byte and leaves the count unchanged. A read there returns the holding byte.
- R3: A read at address 0 returns the count's bits 7:0 on `bus_rdata` one edge later. At the same edge it copies bits 15:8 into the holding byte. A later read at address 1 returns that copy even if the count has moved on.
- R4: A write at address 0 loads all 16 bits of the count at one edge: bits 15:8 come from the holding byte and bits 7:0 from `bus_wdata`.
- R5: When a write at address 0 and a qualified tick fall in the same cycle, the written value is loaded and the tick is lost.
- R6: With `clk_sel` equal to 0, ticks do not change the count, but bus reads and writes still work.
- R7: Mode 0 counts up by one per tick and wraps from 0xFFFF to 0x0000. The wrapping tick sets the overflow flag.
- R8: Mode 1 counts up by one per tick. A tick that finds the count equal to `top_val` clears it to 0x0000 and sets the overflow flag.
- R9: Mode 2 counts up to `top_val`, then down to 0, then up again. The tick that turns the count around at zero sets the flag. A bus write to the count leaves the current direction unchanged.
- R10: `at_bottom` is 1 exactly when the count is 0x0000. `at_top` is 1 when the count equals the mode's limit, which is 0xFFFF in mode 0 and `top_val` otherwise.
- R11: The flag reads as bit 0 at address 2, and `irq` mirrors it. Writing a 1 to bit 0 at address 2 clears the flag, and writing 0 has no effect. A flag-setting event in the same cycle as a clear leaves the flag set.
- R12: Mode 3 holds the count on every tick, but bus writes still load it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 3 | Clock-select field; zero stops counting |
| tick | input | 1 | Single-cycle timer tick strobe |
| mode | input | 2 | 0 free, 1 clear at limit, 2 up/down, 3 hold |
| top_val | input | 16 | Programmable limit for modes 1 and 2 |
| bus_addr | input | 2 | 0 low byte, 1 holding byte, 2 flag |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe (ignored when `bus_wr` is high) |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Registered bus read data |
| at_top | output | 1 | Count equals the mode's limit |
| at_bottom | output | 1 | Count equals zero |
| irq | output | 1 | Overflow flag, used as interrupt request |

## Verification
Every result of this block appears at the first clock edge after its stimulus. That covers the read data, the holding-byte copy, a 16-bit load, a count step, the limit indications and the flag. The bench drives each stimulus on the falling edge, lets exactly one rising edge pass, and samples 1 ns later, before the next falling edge changes the inputs. The count is observed only by a low-byte read followed by a holding-byte read, each checked at its own edge. Because a read does not change the count, this two-cycle readback does not disturb the value under test.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_FREE    = 2'd0,
    MODE_CLR_TOP = 2'd1,
    MODE_UPDOWN  = 2'd2,
    MODE_HOLD    = 2'd3
  } tmr_mode_e;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } tmr_dir_e;

  localparam logic [1:0] ADDR_LO   = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;

endpackage

// File: rtl/tmr_tick_gate.sv
module tmr_tick_gate #(
  parameter int CS_W = 3
) (
  input  logic            tick,
  input  logic [CS_W-1:0] clk_sel,
  output logic            step_en
);

  // A tick only counts when some clock source is selected.
  assign step_en = tick && (clk_sel != '0);

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] top_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             at_top_q,
  output logic             at_bot_q,
  output logic             ovf_evt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  tmr_mode_e        mode_e;
  tmr_dir_e         dir_q, dir_d;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] limit;

  assign mode_e = tmr_mode_e'(mode);
  assign limit  = (mode_e == MODE_FREE) ? CNT_MAX : top_val;

  always_comb begin
    cnt_d   = cnt_q;
    dir_d   = dir_q;
    ovf_evt = 1'b0;
    if (load) begin
      // Bus load wins; direction is deliberately left alone.
      cnt_d = load_val;
    end else if (step_en) begin
      unique case (mode_e)
        MODE_FREE: begin
          cnt_d   = cnt_q + CNT_ONE;
          ovf_evt = (cnt_q == CNT_MAX);
        end
        MODE_CLR_TOP: begin
          if (cnt_q == top_val) begin
            cnt_d   = '0;
            ovf_evt = 1'b1;
          end else begin
            cnt_d = cnt_q + CNT_ONE;
          end
        end
        MODE_UPDOWN: begin
          if (dir_q == DIR_UP) begin
            if (cnt_q >= top_val) begin
              dir_d = DIR_DOWN;
              cnt_d = cnt_q - CNT_ONE;
            end else begin
              cnt_d = cnt_q + CNT_ONE;
            end
          end else begin
            if (cnt_q == '0) begin
              dir_d   = DIR_UP;
              cnt_d   = CNT_ONE;
              ovf_evt = 1'b1;
            end else begin
              cnt_d = cnt_q - CNT_ONE;
            end
          end
        end
        default: begin
          cnt_d = cnt_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      dir_q    <= DIR_UP;
      at_top_q <= 1'b0;
      at_bot_q <= 1'b1;
    end else begin
      cnt_q    <= cnt_d;
      dir_q    <= dir_d;
      at_top_q <= (cnt_d == limit);
      at_bot_q <= (cnt_d == '0);
    end
  end

  // R5: a bus load lands regardless of any tick in that cycle.
  assert_load_wins_R5: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(load_val)));

  // R6: no load and no qualified tick leaves the count untouched.
  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (!load && !step_en) |=> $stable(cnt_q));

  // R7: a free-mode tick advances by exactly one, modulo the width.
  assert_free_step_R7: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load && mode == MODE_FREE) |=> (cnt_q == $past(cnt_q) + CNT_ONE));

  // R9: turnaround at zero while descending.
  assert_bottom_turn_R9: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load && mode == MODE_UPDOWN && dir_q == DIR_DOWN && cnt_q == '0)
      |=> (cnt_q == CNT_ONE && dir_q == DIR_UP));

  // R12: hold mode ignores ticks.
  assert_hold_mode_R12: assert property (@(posedge clk) disable iff (rst)
    (!load && mode == MODE_HOLD) |=> $stable(cnt_q));

  // R10: zero indication tracks the count register.
  assert_bottom_flag_R10: assert property (@(posedge clk) disable iff (rst)
    at_bot_q == (cnt_q == '0));

endmodule

// File: rtl/tmr_bus_port.sv
module tmr_bus_port
  import tmr_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int ADDR_W = 2,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              ovf_evt,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic              flag_q
);

  logic [BUS_W-1:0] hold_q;
  logic             rd_ok;
  logic             wr_lo, wr_hi, wr_flag, rd_lo;
  logic             flag_clr;

  assign rd_ok    = bus_rd && !bus_wr;
  assign wr_lo    = bus_wr && (bus_addr == ADDR_W'(ADDR_LO));
  assign wr_hi    = bus_wr && (bus_addr == ADDR_W'(ADDR_HI));
  assign wr_flag  = bus_wr && (bus_addr == ADDR_W'(ADDR_FLAG));
  assign rd_lo    = rd_ok && (bus_addr == ADDR_W'(ADDR_LO));
  assign flag_clr = wr_flag && bus_wdata[0];

  assign load     = wr_lo;
  assign load_val = {hold_q, bus_wdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
    end else if (wr_hi) begin
      hold_q <= bus_wdata;
    end else if (rd_lo) begin
      hold_q <= cnt_q[CNT_W-1:BUS_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_ok) begin
      case (bus_addr)
        ADDR_W'(ADDR_LO):   bus_rdata <= cnt_q[BUS_W-1:0];
        ADDR_W'(ADDR_HI):   bus_rdata <= hold_q;
        ADDR_W'(ADDR_FLAG): bus_rdata <= {{(BUS_W-1){1'b0}}, flag_q};
        default:            bus_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (ovf_evt) begin
      flag_q <= 1'b1;
    end else if (flag_clr) begin
      flag_q <= 1'b0;
    end
  end

  // R11: an event always leaves the flag set, even against a clear.
  assert_flag_set_R11: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> flag_q);

  // R11: a clear with no competing event drops the flag.
  assert_flag_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !ovf_evt) |=> !flag_q);

  // R2: a holding-byte write lands in the holding byte.
  assert_hold_write_R2: assert property (@(posedge clk) disable iff (rst)
    wr_hi |=> (hold_q == $past(bus_wdata)));

  // R3: a low-byte read snapshots the upper half.
  assert_snapshot_R3: assert property (@(posedge clk) disable iff (rst)
    rd_lo |=> (hold_q == $past(cnt_q[CNT_W-1:BUS_W])));

endmodule

// File: rtl/bytewide_timer.sv
module bytewide_timer
  import tmr_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int CS_W   = 3,
  parameter int ADDR_W = 2,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CS_W-1:0]   clk_sel,
  input  logic              tick,
  input  logic [1:0]        mode,
  input  logic [CNT_W-1:0]  top_val,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              at_top,
  output logic              at_bottom,
  output logic              irq
);

  logic             step_en;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_evt;

  tmr_tick_gate #(.CS_W(CS_W)) u_gate (
    .tick    (tick),
    .clk_sel (clk_sel),
    .step_en (step_en)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .step_en  (step_en),
    .load     (load),
    .load_val (load_val),
    .mode     (mode),
    .top_val  (top_val),
    .cnt_q    (cnt_q),
    .at_top_q (at_top),
    .at_bot_q (at_bottom),
    .ovf_evt  (ovf_evt)
  );

  tmr_bus_port #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_bus (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .cnt_q     (cnt_q),
    .ovf_evt   (ovf_evt),
    .bus_rdata (bus_rdata),
    .load      (load),
    .load_val  (load_val),
    .flag_q    (irq)
  );

endmodule

// File: tb/bytewide_timer_bench.sv
`timescale 1ns/1ps
module bytewide_timer_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  clk_sel = 3'd1;
  logic        tick = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [15:0] top_val = 16'd0;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = 8'd0;
  logic [7:0]  bus_rdata;
  logic        at_top, at_bottom, irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  bytewide_timer u_bytewide_timer (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .tick(tick), .mode(mode),
    .top_val(top_val), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .at_top(at_top),
    .at_bottom(at_bottom), .irq(irq)
  );

  // Vector fields: wr, rd, addr[1:0], data[7:0], tick, chk, exp[7:0]
  localparam int NV = 18;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 1'b0, 2'd1, 8'h12, 1'b0, 1'b0, 8'h00},  // R2 hold byte 12
    {1'b1, 1'b0, 2'd0, 8'h34, 1'b0, 1'b0, 8'h00},  // R4 load 1234
    {1'b0, 1'b1, 2'd0, 8'h00, 1'b0, 1'b1, 8'h34},  // R3 low byte
    {1'b0, 1'b1, 2'd1, 8'h00, 1'b0, 1'b1, 8'h12},  // R4 high via hold
    {1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 8'h00},  // R7 -> 1235
    {1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 8'h00},  // R7 -> 1236
    {1'b0, 1'b1, 2'd0, 8'h00, 1'b1, 1'b1, 8'h36},  // R3 read 36, -> 1237
    {1'b0, 1'b1, 2'd0, 8'h00, 1'b0, 1'b1, 8'h37},  // R7 stepped
    {1'b1, 1'b0, 2'd1, 8'hAB, 1'b0, 1'b0, 8'h00},
    {1'b1, 1'b0, 2'd0, 8'hFE, 1'b1, 1'b0, 8'h00},  // R5 write vs tick
    {1'b0, 1'b1, 2'd0, 8'h00, 1'b0, 1'b1, 8'hFE},  // R5
    {1'b0, 1'b1, 2'd1, 8'h00, 1'b0, 1'b1, 8'hAB},  // R5
    {1'b1, 1'b0, 2'd1, 8'h00, 1'b0, 1'b0, 8'h00},
    {1'b1, 1'b0, 2'd0, 8'hFF, 1'b0, 1'b0, 8'h00},  // 00FF
    {1'b0, 1'b1, 2'd0, 8'h00, 1'b0, 1'b1, 8'hFF},  // R3 snapshot 00
    {1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 8'h00},  // -> 0100
    {1'b0, 1'b1, 2'd1, 8'h00, 1'b0, 1'b1, 8'h00},  // R3 stale copy
    {1'b0, 1'b1, 2'd0, 8'h00, 1'b0, 1'b1, 8'h00}   // R3 live low
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic r, input logic [1:0] a,
                     input logic [7:0] d, input logic t);
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; tick = t;
    @(posedge clk);
    #1;
    bus_wr = 1'b0; bus_rd = 1'b0; tick = 1'b0;
  endtask

  task automatic read16(output logic [15:0] v);
    cyc(1'b0, 1'b1, 2'd0, 8'h00, 1'b0);
    v[7:0] = bus_rdata;
    cyc(1'b0, 1'b1, 2'd1, 8'h00, 1'b0);
    v[15:8] = bus_rdata;
  endtask

  task automatic write16(input logic [15:0] v);
    cyc(1'b1, 1'b0, 2'd1, v[15:8], 1'b0);
    cyc(1'b1, 1'b0, 2'd0, v[7:0], 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 2'd0, 8'h00, 1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 rdata", bus_rdata, 8'h00);
    check("R1 irq", irq, 1'b0);
    check("R1 at_bottom", at_bottom, 1'b1);
    check("R1 at_top", at_top, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    read16(v);
    check("R1 count", v, 16'h0000);

    // Vector table, mode 0, clock selected
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][21], VEC[i][20], VEC[i][19:18], VEC[i][17:10], VEC[i][9]);
      if (VEC[i][8]) check("R3/R4/R5 vector", bus_rdata, VEC[i][7:0]);
    end

    // R6: stopped counter, bus still live
    clk_sel = 3'd0;
    write16(16'h0040);
    ticks(3);
    read16(v);
    check("R6 stopped count", v, 16'h0040);
    clk_sel = 3'd1;

    // R2: holding-byte write leaves count alone
    cyc(1'b1, 1'b0, 2'd1, 8'h77, 1'b0);
    cyc(1'b0, 1'b1, 2'd1, 8'h00, 1'b0);
    check("R2 hold readback", bus_rdata, 8'h77);
    read16(v);
    check("R2 count unchanged", v, 16'h0040);

    // R7 / R10: wrap in free mode
    write16(16'hFFFF);
    check("R10 at_top at FFFF", at_top, 1'b1);
    check("R10 at_bottom off", at_bottom, 1'b0);
    check("R7 no flag yet", irq, 1'b0);
    ticks(1);
    check("R7 flag on wrap", irq, 1'b1);
    check("R10 at_bottom at 0", at_bottom, 1'b1);
    read16(v);
    check("R7 wrapped count", v, 16'h0000);

    // R11: flag read and clear
    cyc(1'b0, 1'b1, 2'd2, 8'h00, 1'b0);
    check("R11 flag read", bus_rdata, 8'h01);
    cyc(1'b1, 1'b0, 2'd2, 8'h00, 1'b0);
    check("R11 write 0 no effect", irq, 1'b1);
    cyc(1'b1, 1'b0, 2'd2, 8'h01, 1'b0);
    check("R11 write 1 clears", irq, 1'b0);
    write16(16'hFFFF);
    cyc(1'b1, 1'b0, 2'd2, 8'h01, 1'b1);
    check("R11 set beats clear", irq, 1'b1);
    cyc(1'b1, 1'b0, 2'd2, 8'h01, 1'b0);
    check("R11 cleared again", irq, 1'b0);

    // R8: clear at limit
    mode = 2'd1;
    top_val = 16'd5;
    write16(16'h0003);
    ticks(2);
    check("R10 at_top at limit", at_top, 1'b1);
    check("R8 no flag before clear", irq, 1'b0);
    ticks(1);
    check("R8 flag at clear", irq, 1'b1);
    read16(v);
    check("R8 cleared count", v, 16'h0000);
    cyc(1'b1, 1'b0, 2'd2, 8'h01, 1'b0);

    // R9: up/down
    mode = 2'd2;
    top_val = 16'd3;
    write16(16'h0000);
    ticks(3);
    check("R9 at_top in updown", at_top, 1'b1);
    ticks(1);
    read16(v);
    check("R9 turned down", v, 16'h0002);
    write16(16'h0002);
    ticks(1);
    read16(v);
    check("R9 direction kept over write", v, 16'h0001);
    ticks(1);
    check("R9 no flag at arrival", irq, 1'b0);
    ticks(1);
    check("R9 flag at bottom turn", irq, 1'b1);
    read16(v);
    check("R9 count after turn", v, 16'h0001);

    // R12: hold mode
    mode = 2'd3;
    ticks(2);
    read16(v);
    check("R12 held", v, 16'h0001);
    write16(16'h0A0B);
    read16(v);
    check("R12 write still loads", v, 16'h0A0B);

    finish_run();
  end

endmodule